// File: doc/BRIEF.md
# Synchronous Character Sync Hunter

This block finds character boundaries in a synchronous serial bit stream that arrives at one bit per bit-enable. While it hunts, it compares the most recent received bits against a programmed pattern, against the fixed bit-oriented flag `01111110`, or against an external sync pin. The sync mode and the multiplier code choose which of these sources is used. Once a sync event has marked a bit as the last bit of a sync pattern, the block counts bit-enables and hands out one assembled character every eight bits, with a strobe.

A link controller programs the mode fields and the pattern, then issues a hunt command to start a search. It reads characters on the boundary strobe and watches `sync_acq` to learn when alignment is present. In flag mode, flag detection never stops. Every flag re-aligns the character counter and raises a flag strobe, which the framing logic above uses to open and close frames.

Top module: `sync_hunter`

## Requirements
- R1: After synchronous reset, `sync_acq`, `char_stb`, `flag_stb` and `char_out` are all zero.
- R2: When `stop_mode` is not `00` the block is inactive. Bit-enables then raise no strobe, and `sync_acq` stays low.
- R3: With `stop_mode`=00 and `mode_sel`=00 (monosync), a hunting block acquires on the bit-enable whose bit completes an 8-bit match with `sync_word[7:0]`. The earliest received of those bits is compared with bit 7. `rate_code` has no effect in this mode.
- R4: With `mode_sel`=01 (bisync), acquisition needs all 16 most recent bits to equal `sync_word`, with the earliest received bit compared with bit 15. An 8-bit partial match does not acquire.
- R5: With `mode_sel`=10 (flag mode), every bit-enable that completes `01111110` raises `flag_stb` and sets `sync_acq`, whether or not the block is hunting. It also restarts the character count, so the next character ends eight bit-enables after the flag.
- R6: With `mode_sel`=11 and `rate_code` 00 or 01, only `ext_sync` high on a bit-enable acquires. A pattern match does not.
- R7: With `mode_sel`=11 and `rate_code`=10, either `ext_sync` or a pattern match acquires. The match covers 8 bits (`sync_word[7:0]`) when `len_8bit`=1 and 6 bits (`sync_word[5:0]`) when `len_8bit`=0.
- R8: With `mode_sel`=11 and `rate_code`=11, flag-mode behaviour applies. In addition, `ext_sync` high on a bit-enable acts as a received flag: it raises `flag_stb`, sets sync and re-aligns the count.
- R9: After a sync event, the 8th following bit-enable and every 8th one after it raise `char_stb` for one cycle. In that same cycle `char_out` holds the last eight bits, with the earliest received bit in bit 7. All outputs are registered and change on the clock edge that samples the bit-enable.
- R10: When a flag completes on the same bit-enable as a character boundary, `char_stb` (with `char_out`=0x7E) and `flag_stb` are both raised in the same cycle.
- R11: `hunt` clears `sync_acq` and the count. It takes priority over a sync event or a flag in the same cycle, which then raises no strobe. No `char_stb` appears until a new sync event.
- R12: In the non-flag modes, once sync is acquired, further pattern matches and `ext_sync` pulses do not move the character boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` and `ext_sync` for one cycle |
| rx_bit | input | 1 | Received serial data bit |
| ext_sync | input | 1 | External sync pin, sampled on bit-enables |
| stop_mode | input | 2 | 00 selects synchronous operation, other codes idle the block |
| mode_sel | input | 2 | 00 monosync, 01 bisync, 10 flag mode, 11 external sync |
| rate_code | input | 2 | Clock multiplier code, used only in external sync |
| len_8bit | input | 1 | Pattern length for external sync with code 10: 1 = 8 bits, 0 = 6 bits |
| sync_word | input | 16 | Programmed sync pattern |
| hunt | input | 1 | Restart the search |
| sync_acq | output | 1 | Character sync acquired |
| char_stb | output | 1 | One-cycle character boundary strobe |
| char_out | output | 8 | Assembled character, valid with `char_stb` |
| flag_stb | output | 1 | One-cycle flag-detected strobe |

## Verification
In flag mode, a flag can finish on exactly the bit that closes a character, so the boundary strobe and the flag strobe fall in the same cycle. The bench sends a flag aligned to the character count and expects both strobes together, with the character reading 0x7E. It then sends a flag displaced by three bits and checks that the next character boundary moves to eight bits after that flag. A second collision, a hunt on the bit that completes a flag, is judged by requiring that no strobe appears and sync stays low.

// File: rtl/sync_hunter_pkg.sv
package sync_hunter_pkg;

    localparam int CHAR_W  = 8;
    localparam int PAT_W   = 2 * CHAR_W;
    localparam int SHORT_W = 6;
    localparam int CNT_W   = $clog2(CHAR_W);

    localparam logic [CHAR_W-1:0] FLAG_WORD = 8'h7E;

    typedef enum logic [1:0] {
        SM_MONO = 2'b00,
        SM_BI   = 2'b01,
        SM_FLAG = 2'b10,
        SM_EXT  = 2'b11
    } sync_mode_e;

    typedef enum logic [1:0] {
        MUL_X1  = 2'b00,
        MUL_X16 = 2'b01,
        MUL_X32 = 2'b10,
        MUL_X64 = 2'b11
    } mult_e;

    // Resolved detection rule after combining all configuration fields
    typedef enum logic [2:0] {
        RULE_OFF,
        RULE_MONO,
        RULE_BI,
        RULE_FLAG,
        RULE_PIN,
        RULE_PIN_OR_MATCH,
        RULE_FLAG_PIN
    } rule_e;

    typedef struct packed {
        logic align;   // marks this bit as last bit of a sync pattern
        logic flag;    // a flag (real or forced) completed on this bit
    } sync_evt_t;

    function automatic rule_e pick_rule(logic [1:0] stop_f, sync_mode_e m, mult_e x);
        rule_e r;
        r = RULE_OFF;
        if (stop_f == 2'b00) begin
            unique case (m)
                SM_MONO: r = RULE_MONO;
                SM_BI:   r = RULE_BI;
                SM_FLAG: r = RULE_FLAG;
                SM_EXT: begin
                    unique case (x)
                        MUL_X1, MUL_X16: r = RULE_PIN;
                        MUL_X32:         r = RULE_PIN_OR_MATCH;
                        MUL_X64:         r = RULE_FLAG_PIN;
                        default:         r = RULE_OFF;
                    endcase
                end
                default: r = RULE_OFF;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sh_history.sv
module sh_history
    import sync_hunter_pkg::*;
#(
    parameter int DEPTH = PAT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             rx_bit,
    output logic [DEPTH-1:0] next_hist
);
    logic [DEPTH-1:0] hist_q;

    // Newest bit enters at bit 0; earlier bits move toward the MSB
    assign next_hist = {hist_q[DEPTH-2:0], rx_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (bit_en) begin
            hist_q <= next_hist;
        end
    end
endmodule

// File: rtl/sh_detect.sv
module sh_detect
    import sync_hunter_pkg::*;
(
    input  rule_e            rule,
    input  logic             bit_en,
    input  logic             hunting,
    input  logic             ext_sync,
    input  logic             len_8bit,
    input  logic [PAT_W-1:0] next_hist,
    input  logic [PAT_W-1:0] sync_word,
    output sync_evt_t        evt
);
    logic byte_hit;
    logic word_hit;
    logic short_hit;
    logic flag_hit;

    always_comb begin
        byte_hit  = (next_hist[CHAR_W-1:0] == sync_word[CHAR_W-1:0]);
        word_hit  = (next_hist == sync_word);
        short_hit = len_8bit ? byte_hit
                             : (next_hist[SHORT_W-1:0] == sync_word[SHORT_W-1:0]);
        flag_hit  = (next_hist[CHAR_W-1:0] == FLAG_WORD);
    end

    always_comb begin
        evt = '0;
        unique case (rule)
            RULE_MONO:         evt.align = hunting & byte_hit;
            RULE_BI:           evt.align = hunting & word_hit;
            RULE_PIN:          evt.align = hunting & ext_sync;
            RULE_PIN_OR_MATCH: evt.align = hunting & (ext_sync | short_hit);
            RULE_FLAG: begin
                evt.flag  = flag_hit;
                evt.align = flag_hit;
            end
            RULE_FLAG_PIN: begin
                evt.flag  = flag_hit | ext_sync;
                evt.align = flag_hit | ext_sync;
            end
            default:           evt = '0;
        endcase
        if (!bit_en) begin
            evt = '0;
        end
    end
endmodule

// File: rtl/sh_framer.sv
module sh_framer
    import sync_hunter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              bit_en,
    input  sync_evt_t         evt,
    input  logic [CHAR_W-1:0] next_char,
    output logic              hunting,
    output logic              sync_acq,
    output logic              char_stb,
    output logic [CHAR_W-1:0] char_out,
    output logic              flag_stb
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(CHAR_W - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             boundary;

    assign hunting  = ~sync_acq;
    assign boundary = sync_acq && (cnt_q == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_acq <= 1'b0;
            cnt_q    <= '0;
            char_stb <= 1'b0;
            char_out <= '0;
            flag_stb <= 1'b0;
        end else begin
            char_stb <= 1'b0;
            flag_stb <= 1'b0;
            if (clear) begin
                sync_acq <= 1'b0;
                cnt_q    <= '0;
            end else if (bit_en) begin
                if (boundary) begin
                    char_stb <= 1'b1;
                    char_out <= next_char;
                end
                flag_stb <= evt.flag;
                if (evt.align) begin
                    sync_acq <= 1'b1;
                    cnt_q    <= '0;
                end else if (sync_acq) begin
                    cnt_q <= boundary ? '0 : cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_hunter_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              ext_sync,
    input  logic [1:0]        stop_mode,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        rate_code,
    input  logic              len_8bit,
    input  logic [PAT_W-1:0]  sync_word,
    input  logic              hunt,
    output logic              sync_acq,
    output logic              char_stb,
    output logic [CHAR_W-1:0] char_out,
    output logic              flag_stb
);
    rule_e            rule;
    logic             idle;
    logic             hunting;
    logic [PAT_W-1:0] next_hist;
    sync_evt_t        evt;

    assign rule = pick_rule(stop_mode, sync_mode_e'(mode_sel), mult_e'(rate_code));
    assign idle = (rule == RULE_OFF);

    sh_history #(.DEPTH(PAT_W)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .rx_bit    (rx_bit),
        .next_hist (next_hist)
    );

    sh_detect u_det (
        .rule      (rule),
        .bit_en    (bit_en),
        .hunting   (hunting),
        .ext_sync  (ext_sync),
        .len_8bit  (len_8bit),
        .next_hist (next_hist),
        .sync_word (sync_word),
        .evt       (evt)
    );

    sh_framer u_frm (
        .clk       (clk),
        .rst       (rst),
        .clear     (hunt | idle),
        .bit_en    (bit_en),
        .evt       (evt),
        .next_char (next_hist[CHAR_W-1:0]),
        .hunting   (hunting),
        .sync_acq  (sync_acq),
        .char_stb  (char_stb),
        .char_out  (char_out),
        .flag_stb  (flag_stb)
    );
endmodule

// File: rtl/sync_hunter_chk.sv
module sync_hunter_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_en,
    input logic [1:0] stop_mode,
    input logic [1:0] mode_sel,
    input logic [1:0] rate_code,
    input logic       hunt,
    input logic       sync_acq,
    input logic       char_stb,
    input logic [7:0] char_out,
    input logic       flag_stb
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_mode != 2'b00) |=> (!sync_acq && !char_stb && !flag_stb));

    // R9
    stb_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
        char_stb |-> ($past(sync_acq) && $past(bit_en)));

    // R9
    acq_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_acq) |-> $past(bit_en));

    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !char_stb |-> $stable(char_out));

    // R11
    hunt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hunt |=> (!sync_acq && !char_stb && !flag_stb));

    // R5
    flag_mode_chk: assert property (@(posedge clk) disable iff (rst)
        flag_stb |-> $past((stop_mode == 2'b00) &&
                           ((mode_sel == 2'b10) || (mode_sel == 2'b11 && rate_code == 2'b11))));
endmodule

bind sync_hunter sync_hunter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .stop_mode (stop_mode),
    .mode_sel  (mode_sel),
    .rate_code (rate_code),
    .hunt      (hunt),
    .sync_acq  (sync_acq),
    .char_stb  (char_stb),
    .char_out  (char_out),
    .flag_stb  (flag_stb)
);

// File: tb/sync_hunter_test.sv
module sync_hunter_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic        ext_sync = 1'b0;
    logic [1:0]  stop_mode = 2'b00;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  rate_code = 2'b00;
    logic        len_8bit = 1'b1;
    logic [15:0] sync_word = 16'h0000;
    logic        hunt = 1'b0;
    logic        sync_acq;
    logic        char_stb;
    logic [7:0]  char_out;
    logic        flag_stb;

    int errors = 0;
    int checks = 0;

    sync_hunter uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit), .ext_sync(ext_sync),
        .stop_mode(stop_mode), .mode_sel(mode_sel), .rate_code(rate_code),
        .len_8bit(len_8bit), .sync_word(sync_word), .hunt(hunt),
        .sync_acq(sync_acq), .char_stb(char_stb), .char_out(char_out), .flag_stb(flag_stb)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs updated
    task automatic send_bit(input logic b, input logic p);
        bit_en = 1'b1;
        rx_bit = b;
        ext_sync = p;
        @(negedge clk);
        bit_en = 1'b0;
        ext_sync = 1'b0;
    endtask

    // Bits go out MSB first; pin_mask bit 7 goes with the first bit
    task automatic send_byte(input logic [7:0] d, input logic [7:0] pin_mask,
                             output int sync_idx, output int stb_idx, output int flag_idx,
                             output int n_stb, output int n_flag, output logic [7:0] stb_data);
        sync_idx = -1; stb_idx = -1; flag_idx = -1; n_stb = 0; n_flag = 0; stb_data = 8'h00;
        for (int i = 0; i < 8; i++) begin
            send_bit(d[7-i], pin_mask[7-i]);
            if (sync_acq && sync_idx < 0) sync_idx = i;
            if (char_stb) begin stb_idx = i; stb_data = char_out; n_stb++; end
            if (flag_stb) begin flag_idx = i; n_flag++; end
        end
    endtask

    task automatic do_hunt();
        hunt = 1'b1;
        @(negedge clk);
        hunt = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "sync_acq after reset", int'(sync_acq), 0);
        check("R1", "char_stb after reset", int'(char_stb), 0);
        check("R1", "flag_stb after reset", int'(flag_stb), 0);
        check("R1", "char_out after reset", int'(char_out), 0);
    endtask

    task automatic t_mono();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b00; rate_code = 2'b11; sync_word = 16'h00A5;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        check("R3", "no sync on zeros", si, -1);
        send_byte(8'hA5, 8'h00, si, bi, fi, ns, nf, dd);
        check("R3", "sync bit index on pattern", si, 7);
        send_byte(8'h3C, 8'h00, si, bi, fi, ns, nf, dd);
        check("R9", "strobe bit index", bi, 7);
        check("R9", "strobe count", ns, 1);
        check("R9", "char value", int'(dd), 8'h3C);
        do_hunt();
        check("R11", "sync cleared by hunt", int'(sync_acq), 0);
        send_byte(8'h3C, 8'h00, si, bi, fi, ns, nf, dd);
        check("R11", "no strobe while hunting", ns, 0);
    endtask

    task automatic t_bisync();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b01; sync_word = 16'hB34D;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h4D, 8'h00, si, bi, fi, ns, nf, dd);
        check("R4", "low byte alone no sync", si, -1);
        send_byte(8'hB3, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h4D, 8'h00, si, bi, fi, ns, nf, dd);
        check("R4", "sync on full 16-bit match", si, 7);
        send_byte(8'h5A, 8'h00, si, bi, fi, ns, nf, dd);
        check("R9", "bisync char value", int'(dd), 8'h5A);
    endtask

    task automatic t_flag();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b10;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h7E, 8'h00, si, bi, fi, ns, nf, dd);
        check("R5", "flag strobe index", fi, 7);
        check("R5", "sync on flag", si, 7);
        send_byte(8'h81, 8'h00, si, bi, fi, ns, nf, dd);
        check("R9", "char after flag", int'(dd), 8'h81);
        check("R5", "no flag in data", nf, 0);
        send_byte(8'h7E, 8'h00, si, bi, fi, ns, nf, dd);
        check("R10", "boundary strobe with flag", bi, 7);
        check("R10", "flag strobe same bit", fi, 7);
        check("R10", "char reads flag", int'(dd), 8'h7E);
        send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b0, 1'b0);
        send_byte(8'h7E, 8'h00, si, bi, fi, ns, nf, dd);
        check("R5", "displaced flag seen", fi, 7);
        send_byte(8'h55, 8'h00, si, bi, fi, ns, nf, dd);
        check("R5", "realigned strobe index", bi, 7);
        check("R5", "realigned char", int'(dd), 8'h55);
        // hunt on the bit that completes a flag
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        for (int i = 0; i < 7; i++) send_bit(i != 0, 1'b0);
        hunt = 1'b1;
        send_bit(1'b0, 1'b0);
        hunt = 1'b0;
        check("R11", "flag suppressed by hunt", int'(flag_stb), 0);
        check("R11", "sync held low by hunt", int'(sync_acq), 0);
    endtask

    task automatic t_idle();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b10; stop_mode = 2'b01;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h7E, 8'h00, si, bi, fi, ns, nf, dd);
        check("R2", "no flag when idle", nf, 0);
        check("R2", "no sync when idle", si, -1);
        stop_mode = 2'b00;
    endtask

    task automatic t_ext_pin();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b11; rate_code = 2'b00; sync_word = 16'h00A5;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'hA5, 8'h00, si, bi, fi, ns, nf, dd);
        check("R6", "pattern ignored", si, -1);
        send_byte(8'h00, 8'h01, si, bi, fi, ns, nf, dd);
        check("R6", "pin acquires", si, 7);
        send_byte(8'hC3, 8'h20, si, bi, fi, ns, nf, dd);
        check("R12", "boundary unmoved by pin", bi, 7);
        check("R12", "single strobe", ns, 1);
        check("R12", "char value", int'(dd), 8'hC3);
    endtask

    task automatic t_ext_match();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b11; rate_code = 2'b10; len_8bit = 1'b0; sync_word = 16'h002D;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h2D, 8'h00, si, bi, fi, ns, nf, dd);
        check("R7", "6-bit match acquires", si, 7);
        len_8bit = 1'b1; sync_word = 16'h00A5;
        do_hunt();
        send_byte(8'h00, 8'h00, si, bi, fi, ns, nf, dd);
        send_byte(8'h2D, 8'h00, si, bi, fi, ns, nf, dd);
        check("R7", "8-bit length rejects 6-bit tail", si, -1);
        send_byte(8'h00, 8'h10, si, bi, fi, ns, nf, dd);
        check("R7", "pin acquires", si, 3);
    endtask

    task automatic t_ext_flag();
        int si, bi, fi, ns, nf; logic [7:0] dd;
        mode_sel = 2'b11; rate_code = 2'b11;
        do_hunt();
        send_byte(8'h00, 8'h10, si, bi, fi, ns, nf, dd);
        check("R8", "pin acts as flag", fi, 3);
        check("R8", "pin sets sync", si, 3);
        send_byte(8'hF0, 8'h00, si, bi, fi, ns, nf, dd);
        check("R8", "strobe after forced flag", bi, 3);
        check("R8", "char after forced flag", int'(dd), 8'h0F);
        send_byte(8'h7E, 8'h00, si, bi, fi, ns, nf, dd);
        check("R8", "real flag still seen", fi, 7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mono();
        t_bisync();
        t_flag();
        t_idle();
        t_ext_pin();
        t_ext_match();
        t_ext_flag();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule